// File: doc/BRIEF.md
# Banked GPIO Controller with Edge Interrupts

This block is a memory-mapped general-purpose I/O controller for 71 pins. The pins are grouped into three banks, and each bank is up to 32 bits wide. Each bank has its own window of ten word registers on a simple 32-bit register bus. Through its window, software sets pin directions and drives output levels. It can update output bits and edge-interrupt enables atomically through write-one-to-set and write-one-to-clear ports, and it reads back the pin levels after synchronization.

Every pin input passes through a two-flop synchronizer. A delayed copy of the synchronized level is used to detect rising and falling edges. Each edge direction has its own per-pin enable mask. An enabled edge sets a sticky per-pin status bit, and software clears that bit by writing a one to it. Each bank drives its own interrupt output, which is high whenever any status bit of that bank is set. The controller drives a per-pin output value and an output enable, which an external pad cell combines into a tri-state pin.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: Bank b's window starts at byte offset 0x10 + 0x28*b. Pin p lives in bank p/32 at bit p%32. The window's registers sit at offsets 0x00 direction, 0x04 output data, 0x08 output set, 0x0C output clear, 0x10 input, 0x14 rising-enable set, 0x18 rising-enable clear, 0x1C falling-enable set, 0x20 falling-enable clear and 0x24 status. Bank 2 implements bits 0..6 only, and its bits 7..31 read as 0.
- R2: After reset every direction bit is 1 (input), so the direction registers read 0xFFFFFFFF, 0xFFFFFFFF and 0x0000007F. Also after reset, pin_oe, pin_out, bank_irq and bus_rdata are all 0, and both enable masks and the status register are 0.
- R3: A direction bit of 1 means input and 0 means output. The cycle after a direction write, pin_oe holds the bitwise inverse of the written value.
- R4: A write to the output data register loads the output latch. A write to the set port drives a 1 at each bit written 1, and a write to the clear port drives a 0 at each bit written 1. Bits written 0 are left unchanged. A read of the data, set or clear offset returns the latch.
- R5: The input register returns the synchronized pin level whatever the direction, so it can differ from the driven value. Suppose a pin changes before clock edge k. A read issued at edge k+1 still returns the old level, and a read issued at edge k+2 returns the new one. Writes to the input register change nothing.
- R6: The rising and falling enable masks each have a set port and a clear port, both with write-one semantics. A read of either port returns the current mask. An edge whose mask bit is 0 sets no status bit.
- R7: An enabled rising edge (synchronized level 0 to 1) or an enabled falling edge (1 to 0) on a pin sets that pin's status bit. Suppose the pin changes before edge k: the status bit is set at edge k+2, and bank_irq[b] rises at the same edge. A status bit stays set until a 1 is written to it. Writing 0 has no effect.
- R8: If a status clear and a new enabled edge on the same bit fall in the same cycle, the bit stays set.
- R9: Read data is registered and appears in the cycle after the read request. Reads of unmapped or misaligned offsets return 0.
- R10: An event on a pin raises only its own bank's interrupt output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Byte offset from controller base |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | 71 | Pad input levels (asynchronous) |
| pin_out | output | 71 | Output latch driven to pads |
| pin_oe | output | 71 | Pad output enable, 1 = drive |
| bank_irq | output | 3 | Per-bank interrupt, OR of the bank's status bits |

## Verification
Two functions can fall in the same cycle: software clearing a status bit, and a freshly detected enabled edge setting that same bit. The bench provokes the clash by changing a pin and then placing the write-one-to-clear exactly on the third clock edge after the change, which is where the synchronizer delivers the new edge. The bench judges the outcome from bank_irq staying high and from the status bit reading back as 1, then confirms that a later plain clear does empty the bit.

// File: rtl/gpio_ctrl_pkg.sv
package gpio_ctrl_pkg;

  localparam int REG_COUNT = 10;

  // word index within a bank window; the order is the bus address map
  typedef enum logic [3:0] {
    RI_DIR  = 4'd0,
    RI_OUT  = 4'd1,
    RI_OSET = 4'd2,
    RI_OCLR = 4'd3,
    RI_IN   = 4'd4,
    RI_RSET = 4'd5,
    RI_RCLR = 4'd6,
    RI_FSET = 4'd7,
    RI_FCLR = 4'd8,
    RI_STAT = 4'd9
  } reg_idx_e;

endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] din,
  output logic [N-1:0] lvl,
  output logic [N-1:0] rise,
  output logic [N-1:0] fall
);

  logic [N-1:0] meta_q, sync_q, prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= din;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign lvl  = sync_q;
  assign rise = sync_q & ~prev_q;
  assign fall = ~sync_q & prev_q;

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_ctrl_pkg::*;
#(
  parameter int NBITS = 32,
  parameter int DW    = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  reg_idx_e         idx,
  input  logic [NBITS-1:0] wdata,
  input  logic [NBITS-1:0] lvl,
  input  logic [NBITS-1:0] rise,
  input  logic [NBITS-1:0] fall,
  output logic [DW-1:0]    rdata,
  output logic [NBITS-1:0] out_q,
  output logic [NBITS-1:0] oe,
  output logic             irq
);

  logic [NBITS-1:0] dir_q, ren_q, fen_q, stat_q;
  logic [NBITS-1:0] evt, clr, stat_n;

  assign evt    = (rise & ren_q) | (fall & fen_q);
  assign clr    = (wr_en && idx == RI_STAT) ? wdata : '0;
  // a new event in the same cycle as a clear keeps the bit set
  assign stat_n = (stat_q & ~clr) | evt;

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q  <= '1;
      out_q  <= '0;
      ren_q  <= '0;
      fen_q  <= '0;
      stat_q <= '0;
      irq    <= 1'b0;
    end else begin
      if (wr_en) begin
        case (idx)
          RI_DIR:  dir_q <= wdata;
          RI_OUT:  out_q <= wdata;
          RI_OSET: out_q <= out_q | wdata;
          RI_OCLR: out_q <= out_q & ~wdata;
          RI_RSET: ren_q <= ren_q | wdata;
          RI_RCLR: ren_q <= ren_q & ~wdata;
          RI_FSET: fen_q <= fen_q | wdata;
          RI_FCLR: fen_q <= fen_q & ~wdata;
          default: ;
        endcase
      end
      stat_q <= stat_n;
      irq    <= |stat_n;
    end
  end

  assign oe = ~dir_q;

  always_comb begin
    case (idx)
      RI_DIR:                   rdata = DW'(dir_q);
      RI_OUT, RI_OSET, RI_OCLR: rdata = DW'(out_q);
      RI_IN:                    rdata = DW'(lvl);
      RI_RSET, RI_RCLR:         rdata = DW'(ren_q);
      RI_FSET, RI_FCLR:         rdata = DW'(fen_q);
      RI_STAT:                  rdata = DW'(stat_q);
      default:                  rdata = '0;
    endcase
  end

endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_ctrl_pkg::*;
#(
  parameter int NUM_PINS   = 71,
  parameter int BANK_W     = 32,
  parameter int ADDR_W     = 8,
  parameter int WIN_BASE   = 16,
  parameter int WIN_STRIDE = 40,
  localparam int NUM_BANKS = (NUM_PINS + BANK_W - 1) / BANK_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [BANK_W-1:0]    bus_wdata,
  output logic [BANK_W-1:0]    bus_rdata,
  input  logic [NUM_PINS-1:0]  pin_in,
  output logic [NUM_PINS-1:0]  pin_out,
  output logic [NUM_PINS-1:0]  pin_oe,
  output logic [NUM_BANKS-1:0] bank_irq
);

  localparam int BYTES  = BANK_W / 8;
  localparam int IDX_SH = $clog2(BYTES);
  localparam int WIN_SZ = REG_COUNT * BYTES;

  logic [NUM_PINS-1:0] lvl, rise, fall;
  logic [NUM_BANKS-1:0] hit;
  logic [NUM_BANKS-1:0][BANK_W-1:0] bank_rd;
  logic [BANK_W-1:0] rd_n;

  gpio_pin_sync #(.N(NUM_PINS)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (pin_in),
    .lvl  (lvl),
    .rise (rise),
    .fall (fall)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam int BASE = WIN_BASE + b * WIN_STRIDE;
    localparam int LEFT = NUM_PINS - b * BANK_W;
    localparam int NB   = (LEFT < BANK_W) ? LEFT : BANK_W;

    logic [ADDR_W-1:0] rel;
    reg_idx_e          idx;

    assign rel    = bus_addr - ADDR_W'(BASE);
    assign hit[b] = (bus_addr >= ADDR_W'(BASE)) && (rel < ADDR_W'(WIN_SZ)) &&
                    ((rel & ADDR_W'(BYTES - 1)) == '0);
    assign idx    = reg_idx_e'(rel[IDX_SH +: 4]);

    gpio_bank #(.NBITS(NB), .DW(BANK_W)) u_bank (
      .clk   (clk),
      .rst   (rst),
      .wr_en (bus_wr & hit[b]),
      .idx   (idx),
      .wdata (bus_wdata[NB-1:0]),
      .lvl   (lvl[b*BANK_W +: NB]),
      .rise  (rise[b*BANK_W +: NB]),
      .fall  (fall[b*BANK_W +: NB]),
      .rdata (bank_rd[b]),
      .out_q (pin_out[b*BANK_W +: NB]),
      .oe    (pin_oe[b*BANK_W +: NB]),
      .irq   (bank_irq[b])
    );
  end

  always_comb begin
    rd_n = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (hit[b]) rd_n = rd_n | bank_rd[b];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_n;
  end

endmodule

// File: rtl/gpio_bank_ctrl_chk.sv
module gpio_bank_ctrl_chk #(
  parameter int NUM_PINS   = 71,
  parameter int BANK_W     = 32,
  parameter int ADDR_W     = 8,
  parameter int WIN_BASE   = 16,
  parameter int NUM_BANKS  = 3
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 bus_wr,
  input logic                 bus_rd,
  input logic [ADDR_W-1:0]    bus_addr,
  input logic [BANK_W-1:0]    bus_wdata,
  input logic [BANK_W-1:0]    bus_rdata,
  input logic [NUM_PINS-1:0]  pin_out,
  input logic [NUM_PINS-1:0]  pin_oe,
  input logic [NUM_BANKS-1:0] bank_irq
);

  localparam logic [ADDR_W-1:0] A_DIR  = ADDR_W'(WIN_BASE);
  localparam logic [ADDR_W-1:0] A_OSET = ADDR_W'(WIN_BASE + 8);
  localparam logic [ADDR_W-1:0] A_OCLR = ADDR_W'(WIN_BASE + 12);
  localparam logic [ADDR_W-1:0] A_IN   = ADDR_W'(WIN_BASE + 16);

  AST_DIR_TO_OE: assert property (@(posedge clk) disable iff (rst)
    bus_wr && bus_addr == A_DIR |=> pin_oe[BANK_W-1:0] == ~$past(bus_wdata)); // R3

  AST_OUT_SET: assert property (@(posedge clk) disable iff (rst)
    bus_wr && bus_addr == A_OSET |=>
      pin_out[BANK_W-1:0] == ($past(pin_out[BANK_W-1:0]) | $past(bus_wdata))); // R4

  AST_OUT_CLR: assert property (@(posedge clk) disable iff (rst)
    bus_wr && bus_addr == A_OCLR |=>
      pin_out[BANK_W-1:0] == ($past(pin_out[BANK_W-1:0]) & ~$past(bus_wdata))); // R4

  AST_IN_WRITE_INERT: assert property (@(posedge clk) disable iff (rst)
    bus_wr && bus_addr == A_IN |=> $stable(pin_out) && $stable(pin_oe)); // R5

  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (rst)
    bank_irq[0] && !bus_wr |=> bank_irq[0]); // R7

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
    bus_rd && bus_addr < A_DIR |=> bus_rdata == '0); // R9

endmodule

bind gpio_bank_ctrl gpio_bank_ctrl_chk #(
  .NUM_PINS  (NUM_PINS),
  .BANK_W    (BANK_W),
  .ADDR_W    (ADDR_W),
  .WIN_BASE  (WIN_BASE),
  .NUM_BANKS (NUM_BANKS)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .pin_out   (pin_out),
  .pin_oe    (pin_oe),
  .bank_irq  (bank_irq)
);

// File: tb/gpio_bank_ctrl_test.sv
`timescale 1ns/1ps
module gpio_bank_ctrl_test;

  localparam int NP = 71;
  localparam int AW = 8;
  localparam int NB = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus_wr = 1'b0;
  logic          bus_rd = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [NP-1:0] pin_in = '0;
  logic [NP-1:0] pin_out, pin_oe;
  logic [NB-1:0] bank_irq;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  gpio_bank_ctrl uut (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_in    (pin_in),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe),
    .bank_irq  (bank_irq)
  );

  task automatic chk(input string tag, input logic [95:0] act, input logic [95:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic int base(input int b);
    return 16 + b * 40;
  endfunction

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = AW'(a); bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = AW'(a);
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(4 * 150000);
    checks++; errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [NP-1:0] exp_out;
    tick(3);
    rst = 1'b0;
    tick(1);

    // R2 reset state
    chk("R2 pin_oe", pin_oe, '0);
    chk("R2 pin_out", pin_out, '0);
    chk("R2 bank_irq", bank_irq, '0);
    chk("R2 rdata", bus_rdata, '0);
    rd(base(0), d); chk("R2 dir bank0", d, 32'hFFFF_FFFF);
    rd(base(1), d); chk("R2 dir bank1", d, 32'hFFFF_FFFF);
    rd(base(2), d); chk("R2 R1 dir bank2", d, 32'h0000_007F);
    rd(base(1) + 20, d); chk("R2 rise mask", d, '0);
    rd(base(2) + 36, d); chk("R2 status", d, '0);

    // R3 direction
    wr(base(0), 32'h0000_00F0);
    chk("R3 oe bank0", pin_oe[31:0], 32'hFFFF_FF0F);
    for (int b = 0; b < NB; b++) wr(base(b), 32'h0);
    chk("R3 oe all out", pin_oe, {NP{1'b1}});

    // R4 R1 set/clear sweep over every pin
    exp_out = '0;
    for (int p = 0; p < NP; p++) begin
      int b;
      logic [31:0] m;
      b = p / 32;
      m = 32'(1) << (p % 32);
      wr(base(b) + 8, m);
      exp_out = NP'(1) << p;
      chk($sformatf("R4 set pin %0d", p), pin_out, exp_out);
      rd(base(b) + 8, d);
      chk($sformatf("R4 R1 setport read pin %0d", p), d, m);
      wr(base(b) + 12, m);
      chk($sformatf("R4 clr pin %0d", p), pin_out, '0);
    end

    // R4 direct data write and partial set/clear
    wr(base(1) + 4, 32'hA5A5_A5A5);
    chk("R4 data bank1", pin_out[63:32], 32'hA5A5_A5A5);
    wr(base(1) + 8, 32'h0000_000A);
    wr(base(1) + 12, 32'hA000_0000);
    chk("R4 set/clr mix", pin_out[63:32], 32'h05A5_A5AF);
    rd(base(1) + 12, d); chk("R4 clrport read", d, 32'h05A5_A5AF);

    // R9 registered reads, unmapped and misaligned give zero
    rd(base(1) + 4, d); chk("R9 mapped read", d, 32'h05A5_A5AF);
    rd(8'h00, d); chk("R9 unmapped low", d, '0);
    rd(base(1) + 4, d);
    rd(8'h88, d); chk("R9 unmapped high", d, '0);
    rd(base(1) + 4, d);
    rd(8'h12, d); chk("R9 misaligned", d, '0);
    wr(base(1) + 4, 32'h0);

    // R1 bank2 upper bits unimplemented
    wr(base(2) + 4, 32'hFFFF_FFFF);
    rd(base(2) + 4, d); chk("R1 bank2 width", d, 32'h0000_007F);
    chk("R1 bank2 pins", pin_out[70:64], 7'h7F);
    wr(base(2) + 4, 32'h0);

    // R5 wired readback: pin 5 is output low but pad held high
    @(negedge clk); pin_in[5] = 1'b1;
    tick(3);
    rd(base(0) + 16, d);
    chk("R5 wired read", {pin_out[5], d[5]}, 2'b01);

    // R5 latency on pin 40
    @(negedge clk);
    pin_in[40] = 1'b1; bus_rd = 1'b1; bus_addr = AW'(base(1) + 16);
    @(negedge clk); chk("R5 latency edge1", bus_rdata[8], 1'b0);
    @(negedge clk); chk("R5 latency edge2", bus_rdata[8], 1'b0);
    @(negedge clk); chk("R5 latency edge3", bus_rdata[8], 1'b1);
    bus_rd = 1'b0;
    pin_in[40] = 1'b0; pin_in[5] = 1'b0;
    tick(4);

    // R5 write to input register is inert
    wr(base(0) + 8, 32'h0000_0101);
    wr(base(0) + 16, 32'hFFFF_FFFF);
    chk("R5 in write out", pin_out[31:0], 32'h0000_0101);
    rd(base(0), d); chk("R5 in write dir", d, '0);
    wr(base(0) + 4, 32'h0);

    // R6 enable masks
    wr(base(0) + 20, 32'h0000_000F);
    wr(base(0) + 24, 32'h0000_0003);
    rd(base(0) + 20, d); chk("R6 rise setport", d, 32'h0000_000C);
    rd(base(0) + 24, d); chk("R6 rise clrport", d, 32'h0000_000C);
    wr(base(1) + 28, 32'h8000_0001);
    rd(base(1) + 32, d); chk("R6 fall mask", d, 32'h8000_0001);
    wr(base(0) + 24, 32'hFFFF_FFFF);
    wr(base(1) + 32, 32'hFFFF_FFFF);
    rd(base(0) + 20, d); chk("R6 rise cleared", d, '0);

    // R7 R10 R6 edge sweep over every pin
    for (int p = 0; p < NP; p++) begin
      int b;
      logic [31:0] m;
      b = p / 32;
      m = 32'(1) << (p % 32);
      wr(base(b) + 20, m);
      wr(base(b) + 28, m);
      @(negedge clk); pin_in[p] = 1'b1;
      tick(2);
      chk($sformatf("R7 early pin %0d", p), bank_irq, '0);
      tick(1);
      chk($sformatf("R7 R10 rise pin %0d", p), bank_irq, NB'(1) << b);
      rd(base(b) + 36, d); chk($sformatf("R7 status pin %0d", p), d, m);
      wr(base(b) + 36, 32'h0);
      chk($sformatf("R7 w0 pin %0d", p), bank_irq, NB'(1) << b);
      wr(base(b) + 36, m);
      chk($sformatf("R7 clear pin %0d", p), bank_irq, '0);
      wr(base(b) + 24, m);
      @(negedge clk); pin_in[p] = 1'b0;
      tick(3);
      chk($sformatf("R7 fall pin %0d", p), bank_irq, NB'(1) << b);
      wr(base(b) + 36, m);
      wr(base(b) + 32, m);
      @(negedge clk); pin_in[p] = 1'b1;
      tick(3);
      pin_in[p] = 1'b0;
      tick(3);
      chk($sformatf("R6 disabled pin %0d", p), bank_irq, '0);
    end

    // R8 clear and new edge in the same cycle on pin 3
    wr(base(0) + 20, 32'h8);
    wr(base(0) + 28, 32'h8);
    @(negedge clk); pin_in[3] = 1'b1;
    tick(3);
    chk("R8 setup", bank_irq, 3'b001);
    @(negedge clk); pin_in[3] = 1'b0;
    @(negedge clk);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = AW'(base(0) + 36); bus_wdata = 32'h8;
    @(negedge clk);
    bus_wr = 1'b0;
    chk("R8 irq kept", bank_irq, 3'b001);
    rd(base(0) + 36, d); chk("R8 status kept", d, 32'h8);
    wr(base(0) + 36, 32'h8);
    rd(base(0) + 36, d); chk("R8 later clear", d, '0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule